// File: doc/BRIEF.md
# Twin-Predicated Element Step Sequencer

This block is a hardware sub-program-counter for one vectorised instruction. It sits between decode and issue, holds the main program counter, and walks element indices from zero up to a vector length. Each pass it issues one pair of register numbers, a source and a destination. Each number is a base register taken from the instruction plus an element index. One instruction therefore stands in for an unrolled run of scalar instructions.

The source side and the destination side each have their own step counter and their own predicate mask. A mask is all ones, the bits of an integer register, or one chosen bit out of every 4-bit condition field. Either mask may be complemented. Each counter skips the elements its mask disables, and the two do so independently. Giving only the source a sparse mask compresses the data; giving only the destination one expands it.

The two step counters are visible at the ports and can be written while the block is idle. A loop stopped by an interrupt can be resumed later from the saved steps.

Top module: `elem_step_seq`

## Requirements
- R1: After a synchronous reset every output is zero, and the block is idle with both step counters at 0.
- R2: An issued source register number is `src_base + source index`, and the destination number is `dst_base + destination index`, both modulo 2^REGW.
- R3: Mask mode code 0 (and the spare code 3) enables every element, and the invert bit is ignored in that mode. With VL=1 exactly one pair, `(src_base, dst_base)`, is issued.
- R4: Mode code 1 enables element i when bit i of that side's integer mask input is 1. With the invert bit set, the bit must be 0 instead.
- R5: Mode code 2 enables element i when bit `CRW*i + csel` of `cr_fields` is 1; the invert bit complements it. Field i occupies bits `CRW*i` to `CRW*i+CRW-1`.
- R6: The source counter advances to the next enabled source element, and the destination counter to the next enabled destination element, each on its own. A pair is issued only when both counters find an element below VL, and each counter then moves one past the element it used.
- R7: The loop ends when either counter finds no enabled element below VL. `pc_advance` then pulses for one cycle, `hold_pc` falls, and both steps return to 0. No element at or above VL is ever issued.
- R8: `hold_pc` is high from the cycle after the `start` edge. Pair k (counting from 1) appears k cycles after that edge, and `pc_advance` appears in the cycle after the last pair.
- R9: `halt` while running stops the loop at the next edge without issuing a pair or pulsing `pc_advance`. The step counters keep the values they had.
- R10: `step_we` while idle (and `start` low) loads both step counters. The next `start` resumes from them. A step at or beyond VL ends the loop with no pair issued.
- R11: `step_we` and `start` are ignored while the loop runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the element loop (captures all configuration) |
| vl | input | IDXW | Vector length, 1 to VLMAX |
| src_base | input | REGW | Source base register number |
| dst_base | input | REGW | Destination base register number |
| src_mode | input | 2 | Source mask mode code |
| src_inv | input | 1 | Complement the source mask |
| src_csel | input | CSELW | Source bit select within each condition field |
| dst_mode | input | 2 | Destination mask mode code |
| dst_inv | input | 1 | Complement the destination mask |
| dst_csel | input | CSELW | Destination bit select within each condition field |
| src_int_mask | input | VLMAX | Integer register bits for the source mask |
| dst_int_mask | input | VLMAX | Integer register bits for the destination mask |
| cr_fields | input | VLMAX*CRW | Condition fields, field i at bits CRW*i upward |
| halt | input | 1 | Interrupt: stop the loop and keep the steps |
| step_we | input | 1 | Write both step counters while idle |
| step_src_wr | input | IDXW | Source step value to write |
| step_dst_wr | input | IDXW | Destination step value to write |
| hold_pc | output | 1 | Main program counter held (loop running) |
| pc_advance | output | 1 | One-cycle pulse when the loop completes |
| elem_valid | output | 1 | An element pair is issued this cycle |
| elem_src_reg | output | REGW | Source element register number |
| elem_dst_reg | output | REGW | Destination element register number |
| src_step | output | IDXW | Current source step counter |
| dst_step | output | IDXW | Current destination step counter |

## Verification
The bench builds the block with its defaults: VLMAX=64, REGW=7 and CRW=4. Those values make the full 64-element walk reachable, including an enable found only at element 63, and the same bit excluded once VL drops to 63. Bases near 127 make the register numbers wrap. All four bit selects of the 4-bit condition fields, and a step counter written right at VL, are within reach as well.

// File: rtl/elem_step_pkg.sv
package elem_step_pkg;
  typedef enum logic [1:0] {
    PM_ALL = 2'd0,
    PM_INT = 2'd1,
    PM_CR  = 2'd2,
    PM_RSV = 2'd3
  } pmode_e;
endpackage

// File: rtl/pred_mask_build.sv
module pred_mask_build
  import elem_step_pkg::*;
#(
  parameter int VLMAX = 64,
  parameter int CRW   = 4,
  parameter int CSELW = 2
) (
  input  pmode_e                   mode,
  input  logic                     inv,
  input  logic [CSELW-1:0]         csel,
  input  logic [VLMAX-1:0]         int_bits,
  input  logic [VLMAX*CRW-1:0]     cr_bits,
  output logic [VLMAX-1:0]         mask
);
  for (genvar g = 0; g < VLMAX; g++) begin : g_elem
    logic [CRW-1:0] fld;
    assign fld = cr_bits[g*CRW +: CRW];
    assign mask[g] = (mode == PM_INT) ? (int_bits[g] ^ inv) :
                     (mode == PM_CR)  ? (fld[csel] ^ inv)   : 1'b1;
  end
endmodule

// File: rtl/step_scan.sv
module step_scan #(
  parameter int VLMAX = 64,
  parameter int IDXW  = 7
) (
  input  logic [VLMAX-1:0] mask,
  input  logic [IDXW-1:0]  from,
  input  logic [IDXW-1:0]  vl,
  output logic             found,
  output logic [IDXW-1:0]  idx
);
  logic [VLMAX-1:0] elig;

  for (genvar g = 0; g < VLMAX; g++) begin : g_elig
    assign elig[g] = mask[g] && (IDXW'(g) >= from) && (IDXW'(g) < vl);
  end

  always_comb begin
    found = |elig;
    idx   = '0;
    for (int i = VLMAX - 1; i >= 0; i--) begin
      if (elig[i]) idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/elem_step_seq.sv
module elem_step_seq
  import elem_step_pkg::*;
#(
  parameter int VLMAX = 64,
  parameter int REGW  = 7,
  parameter int CRW   = 4,
  localparam int IDXW  = $clog2(VLMAX + 1),
  localparam int CSELW = $clog2(CRW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [IDXW-1:0]      vl,
  input  logic [REGW-1:0]      src_base,
  input  logic [REGW-1:0]      dst_base,
  input  logic [1:0]           src_mode,
  input  logic                 src_inv,
  input  logic [CSELW-1:0]     src_csel,
  input  logic [1:0]           dst_mode,
  input  logic                 dst_inv,
  input  logic [CSELW-1:0]     dst_csel,
  input  logic [VLMAX-1:0]     src_int_mask,
  input  logic [VLMAX-1:0]     dst_int_mask,
  input  logic [VLMAX*CRW-1:0] cr_fields,
  input  logic                 halt,
  input  logic                 step_we,
  input  logic [IDXW-1:0]      step_src_wr,
  input  logic [IDXW-1:0]      step_dst_wr,
  output logic                 hold_pc,
  output logic                 pc_advance,
  output logic                 elem_valid,
  output logic [REGW-1:0]      elem_src_reg,
  output logic [REGW-1:0]      elem_dst_reg,
  output logic [IDXW-1:0]      src_step,
  output logic [IDXW-1:0]      dst_step
);
  logic [VLMAX-1:0] src_mask_d, dst_mask_d;
  logic [VLMAX-1:0] src_mask_q, dst_mask_q;
  logic [IDXW-1:0]  vl_q;
  logic [REGW-1:0]  src_base_q, dst_base_q;
  logic             busy;
  logic             s_found, d_found;
  logic [IDXW-1:0]  s_idx, d_idx;

  pred_mask_build #(.VLMAX(VLMAX), .CRW(CRW), .CSELW(CSELW)) u_src_mask (
    .mode(pmode_e'(src_mode)), .inv(src_inv), .csel(src_csel),
    .int_bits(src_int_mask), .cr_bits(cr_fields), .mask(src_mask_d)
  );

  pred_mask_build #(.VLMAX(VLMAX), .CRW(CRW), .CSELW(CSELW)) u_dst_mask (
    .mode(pmode_e'(dst_mode)), .inv(dst_inv), .csel(dst_csel),
    .int_bits(dst_int_mask), .cr_bits(cr_fields), .mask(dst_mask_d)
  );

  step_scan #(.VLMAX(VLMAX), .IDXW(IDXW)) u_src_scan (
    .mask(src_mask_q), .from(src_step), .vl(vl_q),
    .found(s_found), .idx(s_idx)
  );

  step_scan #(.VLMAX(VLMAX), .IDXW(IDXW)) u_dst_scan (
    .mask(dst_mask_q), .from(dst_step), .vl(vl_q),
    .found(d_found), .idx(d_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      src_step     <= '0;
      dst_step     <= '0;
      src_mask_q   <= '0;
      dst_mask_q   <= '0;
      vl_q         <= '0;
      src_base_q   <= '0;
      dst_base_q   <= '0;
      elem_valid   <= 1'b0;
      pc_advance   <= 1'b0;
      elem_src_reg <= '0;
      elem_dst_reg <= '0;
    end else begin
      elem_valid <= 1'b0;
      pc_advance <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy       <= 1'b1;
          src_mask_q <= src_mask_d;
          dst_mask_q <= dst_mask_d;
          vl_q       <= vl;
          src_base_q <= src_base;
          dst_base_q <= dst_base;
        end else if (step_we) begin
          src_step <= step_src_wr;
          dst_step <= step_dst_wr;
        end
      end else if (halt) begin
        busy <= 1'b0;
      end else if (s_found && d_found) begin
        elem_valid   <= 1'b1;
        elem_src_reg <= src_base_q + REGW'(s_idx);
        elem_dst_reg <= dst_base_q + REGW'(d_idx);
        src_step     <= s_idx + 1'b1;
        dst_step     <= d_idx + 1'b1;
      end else begin
        busy       <= 1'b0;
        pc_advance <= 1'b1;
        src_step   <= '0;
        dst_step   <= '0;
      end
    end
  end

  assign hold_pc = busy;
endmodule

// File: rtl/elem_step_seq_chk.sv
module elem_step_seq_chk #(
  parameter int VLMAX = 64,
  localparam int IDXW = $clog2(VLMAX + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            halt,
  input logic            step_we,
  input logic [IDXW-1:0] step_src_wr,
  input logic [IDXW-1:0] step_dst_wr,
  input logic            hold_pc,
  input logic            pc_advance,
  input logic            elem_valid,
  input logic [IDXW-1:0] src_step,
  input logic [IDXW-1:0] dst_step
);
  // R7
  adv_clears_chk: assert property (@(posedge clk) disable iff (rst)
    pc_advance |-> (!hold_pc && src_step == '0 && dst_step == '0));

  // R7
  adv_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    pc_advance |-> $past(hold_pc));

  // R6
  issue_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    elem_valid |-> (hold_pc && !pc_advance));

  // R8
  steps_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (elem_valid && $past(elem_valid)) |->
      (src_step > $past(src_step) && dst_step > $past(dst_step)));

  // R9
  halt_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hold_pc) && $past(halt)) |->
      (!hold_pc && !elem_valid && !pc_advance && $stable(src_step) && $stable(dst_step)));

  // R10
  step_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hold_pc) && !$past(start) && $past(step_we)) |->
      (src_step == $past(step_src_wr) && dst_step == $past(step_dst_wr)));
endmodule

bind elem_step_seq elem_step_seq_chk #(.VLMAX(VLMAX)) u_chk (
  .clk(clk), .rst(rst), .start(start), .halt(halt), .step_we(step_we),
  .step_src_wr(step_src_wr), .step_dst_wr(step_dst_wr), .hold_pc(hold_pc),
  .pc_advance(pc_advance), .elem_valid(elem_valid),
  .src_step(src_step), .dst_step(dst_step)
);

// File: tb/elem_step_seq_bench.sv
module elem_step_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic         start = 0, halt = 0, step_we = 0;
  logic [6:0]   vl = 7'd1, ssw = 0, dsw = 0, sb = 0, db = 0;
  logic [1:0]   sm = 0, dm = 0, sc = 0, dc = 0;
  logic         si = 0, di = 0;
  logic [63:0]  sint = 0, dint = 0;
  logic [255:0] cr = 0;

  wire        hold_pc, pc_advance, elem_valid;
  wire [6:0]  elem_src_reg, elem_dst_reg, src_step, dst_step;

  elem_step_seq u_elem_step_seq (
    .clk(clk), .rst(rst), .start(start), .vl(vl), .src_base(sb), .dst_base(db),
    .src_mode(sm), .src_inv(si), .src_csel(sc), .dst_mode(dm), .dst_inv(di), .dst_csel(dc),
    .src_int_mask(sint), .dst_int_mask(dint), .cr_fields(cr), .halt(halt),
    .step_we(step_we), .step_src_wr(ssw), .step_dst_wr(dsw), .hold_pc(hold_pc),
    .pc_advance(pc_advance), .elem_valid(elem_valid), .elem_src_reg(elem_src_reg),
    .elem_dst_reg(elem_dst_reg), .src_step(src_step), .dst_step(dst_step)
  );

  int nchk = 0, nerr = 0;
  int exp_n;
  int exp_s[64], exp_d[64], exp_si[64], exp_di[64];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic bit mb(input bit dside, input int i);
    logic [1:0] mode; bit inv; int sel; logic [63:0] ib;
    mode = dside ? dm : sm; inv = dside ? di : si;
    sel = dside ? int'(dc) : int'(sc); ib = dside ? dint : sint;
    case (mode)
      2'd1: return ib[i] ^ inv;
      2'd2: return cr[4*i+sel] ^ inv;
      default: return 1'b1;
    endcase
  endfunction

  task automatic compute(input int s0, input int d0);
    int s, d, v;
    s = s0; d = d0; v = int'(vl); exp_n = 0;
    while (exp_n < 64) begin
      while (s < v && !mb(1'b0, s)) s++;
      while (d < v && !mb(1'b1, d)) d++;
      if (s >= v || d >= v) break;
      exp_si[exp_n] = s; exp_di[exp_n] = d;
      exp_s[exp_n] = (int'(sb) + s) % 128;
      exp_d[exp_n] = (int'(db) + d) % 128;
      exp_n++; s++; d++;
    end
  endtask

  task automatic write_steps(input int s, input int d);
    @(negedge clk); step_we = 1; ssw = 7'(s); dsw = 7'(d);
    @(negedge clk); step_we = 0;
    chk({src_step, dst_step} == 14'((s << 7) | d), "R10", "step write",
        {src_step, dst_step}, (s << 7) | d);
  endtask

  task automatic exec(input int s0, input int d0, input int halt_at,
                      input bit noise, input string tag);
    int k; bit fin;
    write_steps(s0, d0);
    compute(s0, d0);
    @(negedge clk); start = 1;
    @(negedge clk); start = noise;
    if (noise) begin step_we = 1; ssw = 7'($urandom % 128); dsw = 7'($urandom % 128); end
    chk(hold_pc == 1'b1, "R8", "hold after start", hold_pc, 1);
    k = 0; fin = 0;
    for (int c = 1; c <= 70 && !fin; c++) begin
      @(negedge clk);
      if (halt_at > 0 && c == halt_at + 1) begin
        halt = 0;
        chk(!elem_valid && !pc_advance && !hold_pc, "R9", "stopped",
            {elem_valid, pc_advance, hold_pc}, 0);
        chk({src_step, dst_step} == 14'(((exp_si[halt_at-1]+1) << 7) | (exp_di[halt_at-1]+1)),
            "R9", "kept steps", {src_step, dst_step},
            ((exp_si[halt_at-1]+1) << 7) | (exp_di[halt_at-1]+1));
        fin = 1;
      end else begin
        chk(elem_valid == (c <= exp_n), tag, "valid cycle", elem_valid, c <= exp_n);
        if (elem_valid && k < exp_n) begin
          chk(elem_src_reg == 7'(exp_s[k]) && elem_dst_reg == 7'(exp_d[k]), tag,
              "pair src*128+dst", elem_src_reg * 128 + elem_dst_reg, exp_s[k] * 128 + exp_d[k]);
          k++;
        end
        chk(pc_advance == (c == exp_n + 1), "R8", "advance cycle", pc_advance, c == exp_n + 1);
        if (halt_at > 0 && c == halt_at) halt = 1;
        if (noise && c <= exp_n) begin
          step_we = 1; start = 1; ssw = 7'($urandom % 128); dsw = 7'($urandom % 128);
        end else begin
          step_we = 0; start = 0;
        end
        if (c == exp_n + 1) fin = 1;
      end
    end
    if (halt_at <= 0)
      chk(src_step == 0 && dst_step == 0 && !hold_pc, noise ? "R11" : "R7", "end state",
          {hold_pc, src_step, dst_step}, 0);
  endtask

  task automatic cfg(input int v, input int b0, input int b1,
                     input int m0, input int i0, input int c0,
                     input int m1, input int i1, input int c1);
    vl = 7'(v); sb = 7'(b0); db = 7'(b1);
    sm = 2'(m0); si = 1'(i0); sc = 2'(c0);
    dm = 2'(m1); di = 1'(i1); dc = 2'(c1);
  endtask

  initial begin
    int hs, hd, h;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!hold_pc && !pc_advance && !elem_valid && elem_src_reg == 0 && elem_dst_reg == 0
        && src_step == 0 && dst_step == 0, "R1", "reset outputs",
        {hold_pc, pc_advance, elem_valid, elem_src_reg, elem_dst_reg, src_step, dst_step}, 0);

    cfg(1, 12, 40, 0, 0, 0, 0, 0, 0);        exec(0, 0, 0, 0, "R3");
    cfg(64, 100, 90, 0, 1, 0, 3, 1, 0);      exec(0, 0, 0, 0, "R3");
    cfg(64, 120, 127, 0, 0, 0, 0, 0, 0);     exec(0, 0, 0, 0, "R2");
    sint = 64'h0000_0000_0000_00A5;
    cfg(8, 0, 20, 1, 0, 0, 0, 0, 0);         exec(0, 0, 0, 0, "R4");
    dint = 64'h0000_0000_0000_0F3C;
    cfg(16, 5, 60, 0, 0, 0, 1, 1, 0);        exec(0, 0, 0, 0, "R4");
    for (int i = 0; i < 8; i++) cr[i*32 +: 32] = $urandom;
    cfg(64, 3, 70, 2, 0, 2, 2, 1, 1);        exec(0, 0, 0, 0, "R5");
    cfg(64, 9, 9, 2, 0, 3, 2, 0, 0);         exec(0, 0, 0, 0, "R5");
    dint = 64'h0;
    cfg(10, 0, 0, 0, 0, 0, 1, 0, 0);         exec(0, 0, 0, 0, "R7");
    sint = 64'h8000_0000_0000_0000; dint = 64'h8000_0000_0000_0000;
    cfg(64, 1, 2, 1, 0, 0, 1, 0, 0);         exec(0, 0, 0, 0, "R7");
    cfg(63, 1, 2, 1, 0, 0, 1, 0, 0);         exec(0, 0, 0, 0, "R7");
    sint = 64'hF0F0_F0F0_F0F0_F0F0; dint = 64'h3333_3333_3333_3333;
    cfg(40, 10, 50, 1, 0, 0, 1, 0, 0);       exec(3, 5, 0, 0, "R10");
    cfg(20, 10, 50, 0, 0, 0, 0, 0, 0);       exec(20, 2, 0, 0, "R10");
    cfg(40, 10, 50, 1, 0, 0, 1, 0, 0);       exec(0, 0, 4, 0, "R9");
    hs = exp_si[3] + 1; hd = exp_di[3] + 1;
    exec(hs, hd, 0, 0, "R10");
    cfg(30, 7, 77, 1, 1, 0, 0, 0, 0);        exec(0, 0, 0, 1, "R11");

    for (int r = 0; r < 40; r++) begin
      sint = {$urandom, $urandom}; dint = {$urandom, $urandom};
      for (int i = 0; i < 8; i++) cr[i*32 +: 32] = $urandom;
      cfg(1 + $urandom % 64, $urandom % 128, $urandom % 128,
          $urandom % 4, $urandom % 2, $urandom % 4,
          $urandom % 4, $urandom % 2, $urandom % 4);
      if (r % 5 == 4) begin
        exec($urandom % 65, $urandom % 65, 0, 0, "R10");
      end else if (r % 7 == 3) begin
        compute(0, 0);
        h = (exp_n > 1) ? 1 + int'($urandom % (exp_n - 1)) : 0;
        exec(0, 0, h, 0, "R9");
      end else begin
        exec(0, 0, 0, (r % 6 == 1), "R6");
      end
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R7 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule